// File: doc/BRIEF.md
# Leakage Bin Encoder and Keeper Strength Programmer

This block converts the raw comparator outputs of a multi-channel on-die leakage sensor into a process-bin number. It then turns that number into a strength setting for the programmable keepers on dynamic register-file bitlines. The channels are mirrored at rising ratios, so a leakier die trips more of them. The pattern should read as a thermometer, but comparator offset can leave isolated holes or spikes in it. A cleanup stage removes these before the tripped channels are counted.

The level is only trusted after the measurement enable has been held long enough for the analog front end to settle. The level must then read the same on several successive samples. The accepted level is copied into a keeper setting, where a higher level means a stronger keeper. Leaky, fast dies get robustness, and slow dies get speed from a weaker keeper. Once the fuse-program request has been issued, the keeper setting is frozen permanently. Before any calibration the keeper sits at its strongest value.

Top module: `lkc_keeper_cal`

## Requirements
- R1: After reset, `leak_code` is 0, `code_valid` is 0, `fuse_blown` is 0 and `keeper_sel` is 7 (all three keeper legs on).
- R2: Channels 1 to 4 are each replaced by their neighbours' value when both neighbours agree with each other and disagree with the channel. Channels 0 and 5 are used as they arrive.
- R3: The level is one plus the number of ones in the cleaned pattern (1 to 7). `sense_chan[0]` is the lowest-ratio channel and the first to trip.
- R4: With `meas_en` held high and a steady input, the level is latched on the 19th consecutive rising edge with `meas_en` high, and not before. That is a 16-cycle settle, then three equal samples. `code_valid` is set at that latch.
- R5: A change of the level during sampling restarts the count, so three successive equal samples are needed before anything is latched.
- R6: Deasserting `meas_en` for one cycle discards the settle and sample progress. A new 19-edge measurement is then needed.
- R7: While not fused, each latch sets `keeper_sel` to the level, limited to the range 1 to 7. Bit 0 enables the 1W leg, bit 1 the 2W leg and bit 2 the 4W leg.
- R8: `fuse_prog` sets `fuse_blown` only when `code_valid` is 1, and `fuse_blown` never clears afterwards.
- R9: Once `fuse_blown` is 1, `keeper_sel` no longer changes, while `leak_code` still follows new measurements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_en | input | 1 | Measurement window enable |
| fuse_prog | input | 1 | Request to make the keeper setting permanent |
| sense_chan | input | 6 | Comparator outputs, bit 0 the lowest mirror ratio |
| leak_code | output | 3 | Last accepted leakage level |
| code_valid | output | 1 | A level has been accepted since reset |
| keeper_sel | output | 3 | Binary-weighted keeper leg enables |
| fuse_blown | output | 1 | Keeper setting is frozen |

## Verification
The bench builds the block with its defaults: six channels, a 16-cycle settle and three equal samples. With six channels every one of the 64 comparator patterns can be swept. This covers every bubble shape at every interior position, the untouched edge channels, and all seven levels mapped onto the keeper. The short settle makes each measurement about twenty cycles long. Off-by-one timing at the latch edge, a level change mid-sampling, an enable drop and the fuse freeze can then each be hit in exact cycles.

// File: rtl/lkc_pkg.sv
package lkc_pkg;

  // Limit an integer into [lo, hi]
  function automatic int clamp_int(input int v, input int lo, input int hi);
    int r;
    r = v;
    if (r < lo) r = lo;
    if (r > hi) r = hi;
    return r;
  endfunction

endpackage

// File: rtl/lkc_bubble_enc.sv
module lkc_bubble_enc #(
  parameter int NCH    = 6,
  parameter int CODE_W = $clog2(NCH + 2)
) (
  input  logic [NCH-1:0]    chan_raw,
  output logic [CODE_W-1:0] level_code
);

  logic [NCH-1:0] chan_clean;

  // Isolated-bubble cleanup, interior channels only (R2)
  for (genvar i = 0; i < NCH; i++) begin : g_clean
    if (i == 0 || i == NCH - 1) begin : g_edge
      assign chan_clean[i] = chan_raw[i];
    end else begin : g_mid
      assign chan_clean[i] = (chan_raw[i-1] == chan_raw[i+1]) ? chan_raw[i-1]
                                                               : chan_raw[i];
    end
  end

  // Level = 1 + tripped channel count (R3)
  function automatic int ones_in(input logic [NCH-1:0] v);
    int n;
    n = 0;
    for (int k = 0; k < NCH; k++) n += int'(v[k]);
    return n;
  endfunction

  always_comb begin
    level_code = CODE_W'(ones_in(chan_clean) + 1);
  end

endmodule

// File: rtl/lkc_meas_window.sv
module lkc_meas_window #(
  parameter int MEAS_CYCLES = 16,
  parameter int STABLE_RUNS = 3,
  parameter int CODE_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_en,
  input  logic [CODE_W-1:0] level_code,
  output logic              latch_fire,
  output logic [CODE_W-1:0] latch_code
);

  localparam int WIN_W = $clog2(MEAS_CYCLES + 1);
  localparam int RUN_W = $clog2(STABLE_RUNS + 1);

  logic [WIN_W-1:0]  win_cnt;
  logic [RUN_W-1:0]  run_cnt;
  logic [RUN_W-1:0]  run_next;
  logic [CODE_W-1:0] last_code;
  logic              win_open;
  logic              sample;
  logic              match;

  assign win_open = (win_cnt == WIN_W'(MEAS_CYCLES));
  assign sample   = meas_en && win_open;
  assign match    = (run_cnt != '0) && (level_code == last_code);

  always_comb begin
    if (!match)
      run_next = RUN_W'(1);
    else if (run_cnt == RUN_W'(STABLE_RUNS))
      run_next = run_cnt;
    else
      run_next = run_cnt + RUN_W'(1);
  end

  assign latch_fire = sample && (run_next == RUN_W'(STABLE_RUNS))
                             && (run_cnt  != RUN_W'(STABLE_RUNS));
  assign latch_code = level_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt   <= '0;
      run_cnt   <= '0;
      last_code <= '0;
    end else if (!meas_en) begin
      win_cnt <= '0;
      run_cnt <= '0;
    end else begin
      if (!win_open) win_cnt <= win_cnt + WIN_W'(1);
      if (sample) begin
        last_code <= level_code;
        run_cnt   <= run_next;
      end
    end
  end

  AST_FIRE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |-> $past(meas_en)); // R4
  AST_FIRE_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |-> $past(level_code) == level_code); // R5
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> (run_cnt == '0) && (win_cnt == '0)); // R6

endmodule

// File: rtl/lkc_keeper_store.sv
module lkc_keeper_store #(
  parameter int CODE_W       = 3,
  parameter int KW           = 3,
  parameter int KEEPER_RESET = (1 << KW) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_fire,
  input  logic [CODE_W-1:0] latch_code,
  input  logic              fuse_prog,
  output logic [CODE_W-1:0] leak_code,
  output logic              code_valid,
  output logic [KW-1:0]     keeper_sel,
  output logic              fuse_blown
);

  import lkc_pkg::*;

  localparam int KMAX = (1 << KW) - 1;

  function automatic logic [KW-1:0] to_keeper(input logic [CODE_W-1:0] c);
    return KW'(clamp_int(int'(c), 1, KMAX));
  endfunction

  logic keeper_update;
  logic fuse_set;

  assign keeper_update = latch_fire && !fuse_blown;
  assign fuse_set      = fuse_prog && code_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leak_code  <= '0;
      code_valid <= 1'b0;
      keeper_sel <= KW'(KEEPER_RESET);
      fuse_blown <= 1'b0;
    end else begin
      if (latch_fire) begin
        leak_code  <= latch_code;
        code_valid <= 1'b1;
      end
      if (keeper_update) keeper_sel <= to_keeper(latch_code);
      if (fuse_set)      fuse_blown <= 1'b1;
    end
  end

  AST_KEEPER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    keeper_sel != '0); // R7
  AST_FUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_blown |=> fuse_blown); // R8
  AST_FUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_blown |=> $stable(keeper_sel)); // R9

endmodule

// File: rtl/lkc_keeper_cal.sv
module lkc_keeper_cal #(
  parameter int NCH          = 6,
  parameter int MEAS_CYCLES  = 16,
  parameter int STABLE_RUNS  = 3,
  parameter int KW           = 3,
  parameter int KEEPER_RESET = (1 << KW) - 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       meas_en,
  input  logic       fuse_prog,
  input  logic [5:0] sense_chan,
  output logic [2:0] leak_code,
  output logic       code_valid,
  output logic [2:0] keeper_sel,
  output logic       fuse_blown
);

  localparam int CODE_W = $clog2(NCH + 2);

  logic [CODE_W-1:0] level_code;
  logic              latch_fire;
  logic [CODE_W-1:0] latch_code;

  lkc_bubble_enc #(.NCH(NCH), .CODE_W(CODE_W)) u_enc (
    .chan_raw   (sense_chan),
    .level_code (level_code)
  );

  lkc_meas_window #(
    .MEAS_CYCLES (MEAS_CYCLES),
    .STABLE_RUNS (STABLE_RUNS),
    .CODE_W      (CODE_W)
  ) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_en    (meas_en),
    .level_code (level_code),
    .latch_fire (latch_fire),
    .latch_code (latch_code)
  );

  lkc_keeper_store #(
    .CODE_W       (CODE_W),
    .KW           (KW),
    .KEEPER_RESET (KEEPER_RESET)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_fire (latch_fire),
    .latch_code (latch_code),
    .fuse_prog  (fuse_prog),
    .leak_code  (leak_code),
    .code_valid (code_valid),
    .keeper_sel (keeper_sel),
    .fuse_blown (fuse_blown)
  );

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> (leak_code >= 3'd1) && (leak_code <= 3'(NCH + 1))); // R3

endmodule

// File: tb/test_lkc_keeper_cal.sv
module test_lkc_keeper_cal;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       meas_en = 1'b0;
  logic       fuse_prog = 1'b0;
  logic [5:0] sense_chan = '0;
  logic [2:0] leak_code;
  logic       code_valid;
  logic [2:0] keeper_sel;
  logic       fuse_blown;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  lkc_keeper_cal i_lkc_keeper_cal (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_en    (meas_en),
    .fuse_prog  (fuse_prog),
    .sense_chan (sense_chan),
    .leak_code  (leak_code),
    .code_valid (code_valid),
    .keeper_sel (keeper_sel),
    .fuse_blown (fuse_blown)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Model: interior bit becomes majority of itself and its neighbours
  function automatic int model_level(input logic [5:0] p);
    logic [5:0] f;
    f = p;
    for (int i = 1; i < 5; i++)
      f[i] = (p[i-1] & p[i+1]) | (p[i] & (p[i-1] | p[i+1]));
    return $countones(f) + 1;
  endfunction

  function automatic bit has_bubble(input logic [5:0] p);
    for (int i = 1; i < 5; i++)
      if (p[i-1] == p[i+1] && p[i] != p[i-1]) return 1'b1;
    return 1'b0;
  endfunction

  // Full measurement: check the previous level holds through edge 18,
  // then the new level after edge 19.
  task automatic measure(input logic [5:0] p, input int prev, input bit fused_k,
                         input int kexp);
    int lv;
    lv = model_level(p);
    @(negedge clk);
    sense_chan = p;
    meas_en = 1'b1;
    repeat (18) @(posedge clk);
    @(negedge clk);
    check("R4 no latch before edge 19", int'(leak_code), prev);
    @(posedge clk);
    @(negedge clk);
    if (has_bubble(p)) check("R2 bubble removed", int'(leak_code), lv);
    else               check("R3 level count", int'(leak_code), lv);
    check("R4 valid after latch", int'(code_valid), 1);
    if (fused_k) check("R9 keeper frozen", int'(keeper_sel), kexp);
    else         check("R7 keeper follows level", int'(keeper_sel), lv);
    meas_en = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    #4_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int prev;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset level", int'(leak_code), 0);
    check("R1 reset valid", int'(code_valid), 0);
    check("R1 reset keeper", int'(keeper_sel), 7);
    check("R1 reset fuse", int'(fuse_blown), 0);
    rst_n = 1'b1;

    // R8: fuse request before any valid level is ignored
    @(negedge clk);
    fuse_prog = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fuse_prog = 1'b0;
    check("R8 early fuse ignored", int'(fuse_blown), 0);
    check("R8 keeper untouched", int'(keeper_sel), 7);

    // Sweep every pattern
    prev = 0;
    for (int p = 0; p < 64; p++) begin
      measure(6'(p), prev, 1'b0, 0);
      prev = model_level(6'(p));
    end

    // R5: level changes after the first sample; restart needed
    @(negedge clk);
    sense_chan = 6'b000001;
    meas_en = 1'b1;
    repeat (17) @(posedge clk);
    @(negedge clk);
    sense_chan = 6'b011111;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R5 no latch after change", int'(leak_code), prev);
    @(posedge clk);
    @(negedge clk);
    check("R5 latch after three equal", int'(leak_code), 6);
    meas_en = 1'b0;
    @(posedge clk);
    prev = 6;

    // R6: enable drop mid-settle restarts the window
    @(negedge clk);
    sense_chan = 6'b000011;
    meas_en = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    meas_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    meas_en = 1'b1;
    repeat (18) @(posedge clk);
    @(negedge clk);
    check("R6 restart no early latch", int'(leak_code), prev);
    @(posedge clk);
    @(negedge clk);
    check("R6 latch after full window", int'(leak_code), 3);
    check("R7 keeper level 3", int'(keeper_sel), 3);
    meas_en = 1'b0;
    @(posedge clk);

    // R8: fuse with valid level
    @(negedge clk);
    fuse_prog = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fuse_prog = 1'b0;
    check("R8 fuse blown", int'(fuse_blown), 1);
    @(posedge clk);
    @(negedge clk);
    check("R8 fuse sticky", int'(fuse_blown), 1);

    // R9: level still moves, keeper frozen at 3
    measure(6'b111111, 3, 1'b1, 3);
    measure(6'b000000, 7, 1'b1, 3);
    check("R9 fuse still set", int'(fuse_blown), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule